// File: doc/BRIEF.md
# Packet tag address sequencer

This block serves packet transfers arriving from a remote bus. Each packet names a 12-bit tag and a direction. The tag selects a row in three on-chip tables. One table holds start addresses and one holds resume addresses; both are 32 bits wide. The third holds word counts, 12 bits wide. When a command is accepted, the block loads an address pointer from the start or resume table. It then performs one 32-bit access per word on a local memory master port. After every granted access it writes the advanced pointer back into the resume table. A later packet whose tag carries the 2048 offset therefore continues where the previous packet stopped. This lets a large structure move as a chain of fixed-size packets.

For reads, the word count comes from the size table and the words leave on a valid/ready read stream. For writes, the words arrive on a valid/ready write stream and the packet ends on the beat marked last. Tags whose table index is 511 mark their write accesses for the flash programming path. The host fills the tables through a plain configuration port and can read all three back. The resume table cannot be written from the host.

Stream rules are as follows. A producer holds valid and its data stable until the beat is taken. The read stream holds `rd_valid`, `rd_data` and `rd_last` until `rd_ready` is high at a clock edge. The write stream is taken on an edge where `wr_valid` and `wr_ready` are both high. The memory port holds `mem_req`, `mem_addr`, `mem_we`, `mem_wdata` and `mem_flash` until `mem_gnt`. Read data returns on `mem_rvalid` in a later cycle than the grant. Only one access is outstanding at a time.

Top module: `pkt_tag_seq`

## Requirements
- R1: After reset, `busy`, `mem_req`, `rd_valid` and `wr_ready` are low and `cmd_ready` is high.
- R2: Host table writes use `cfg_sel` 0 for the start table, 1 for the resume table and 2 for the size table. The size table keeps the low 12 bits. A host read returns the entry on `cfg_rdata` one cycle after `cfg_rd_en`, with size entries zero-extended.
- R3: A tag with bit 11 clear and a nonzero value takes its first address from the start table at index tag[8:0]. Tags 512..2047 alias onto the same indices.
- R4: A tag with bit 11 set and nonzero low 11 bits takes its first address from the resume table at index tag[8:0].
- R5: After each granted memory access, the pointer advances by one. The resume entry at the packet's index then holds the address following the last access.
- R6: A read packet performs exactly size-table-entry accesses, returns the words in address order and raises `rd_last` only with the final word.
- R7: A write packet stores each stream word at successive addresses and ends after the beat carrying `wr_last`, whatever the size table holds.
- R8: Host writes with `cfg_sel` = 1 leave the resume table unchanged.
- R9: `mem_flash` is high on every write access of a packet whose table index is 511, and low on all other accesses.
- R10: Tags 0 and 2048 are accepted and rejected. `tag_err` pulses for one cycle, no memory access happens and `busy` stays low.
- R11: A read packet whose size entry is zero pulses `done` with no memory access and no read beat.
- R12: `busy` is high from the cycle after acceptance until the transfer ends, and `cmd_ready` is low throughout. `done` is a one-cycle pulse as `busy` falls.
- R13: Under back-pressure, a pending read beat and a pending memory request hold their valid signal and contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Host table write strobe |
| cfg_rd_en | input | 1 | Host table read strobe |
| cfg_sel | input | 2 | Table select: 0 start, 1 resume, 2 size |
| cfg_idx | input | 9 | Table row |
| cfg_wdata | input | 32 | Host write data |
| cfg_rdata | output | 32 | Host read data, one cycle after the strobe |
| cmd_valid | input | 1 | Packet command valid |
| cmd_ready | output | 1 | Command accepted when high with valid |
| cmd_tag | input | 12 | Packet tag |
| cmd_write | input | 1 | 1 = write packet, 0 = read packet |
| wr_valid | input | 1 | Write stream beat valid |
| wr_ready | output | 1 | Write stream ready |
| wr_data | input | 32 | Write stream word |
| wr_last | input | 1 | Final beat of a write packet |
| rd_valid | output | 1 | Read stream beat valid |
| rd_ready | input | 1 | Read stream ready |
| rd_data | output | 32 | Read stream word |
| rd_last | output | 1 | Final beat of a read packet |
| mem_req | output | 1 | Memory access request |
| mem_gnt | input | 1 | Memory accepts the request |
| mem_we | output | 1 | 1 = write access |
| mem_addr | output | 32 | Word address |
| mem_wdata | output | 32 | Write data |
| mem_flash | output | 1 | Access belongs to a flash programming packet |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 32 | Returned read data |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle pulse at transfer end |
| tag_err | output | 1 | One-cycle pulse on a rejected tag |

## Verification
The bench chains a start-table read with an offset-tag read of the same index. A design that failed to update the resume entry after each grant, or updated it with the wrong address, would replay or skip words. Aliased tags, the two invalid tags and a zero-length read are each run. A wrong decode would touch memory, raise `busy` or hang waiting for beats that never come. Flash marking is checked on index 511 and on an ordinary write. A write packet uses a size entry that differs from its stream length, which exposes a design that counts from the table instead of stopping on the last beat. A run with grant stalls and read back-pressure confirms that held beats do not change, that no beat is lost or duplicated, and that commands stay refused for the whole transfer.

// File: rtl/pkt_seq_pkg.sv
package pkt_seq_pkg;

  typedef enum logic [1:0] {
    TBL_START = 2'd0,
    TBL_CONT  = 2'd1,
    TBL_SIZE  = 2'd2,
    TBL_NONE  = 2'd3
  } tbl_sel_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FETCH = 3'd1,
    ST_RREQ  = 3'd2,
    ST_RWAIT = 3'd3,
    ST_ROUT  = 3'd4,
    ST_WDAT  = 3'd5,
    ST_WREQ  = 3'd6
  } xfer_state_e;

endpackage

// File: rtl/pkt_tag_decode.sv
module pkt_tag_decode #(
  parameter int TAG_W     = 12,
  parameter int IDX_W     = 9,
  parameter int FLASH_IDX = 511
) (
  input  logic [TAG_W-1:0] tag,
  input  logic             is_write,
  output logic [IDX_W-1:0] idx,
  output logic             use_cont,
  output logic             tag_ok,
  output logic             flash
);
  localparam logic [IDX_W-1:0] FLASH_CODE = IDX_W'(FLASH_IDX);

  // top tag bit selects the resume table; the remaining bits must not be all zero
  assign use_cont = tag[TAG_W-1];
  assign idx      = tag[IDX_W-1:0];
  assign tag_ok   = |tag[TAG_W-2:0];
  assign flash    = is_write && (idx == FLASH_CODE);
endmodule

// File: rtl/pkt_addr_tables.sv
module pkt_addr_tables
  import pkt_seq_pkg::*;
#(
  parameter int IDX_W  = 9,
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_en,
  input  logic              hr_en,
  input  tbl_sel_e          h_sel,
  input  logic [IDX_W-1:0]  h_idx,
  input  logic [ADDR_W-1:0] hw_data,
  output logic [ADDR_W-1:0] hr_data,
  input  logic [IDX_W-1:0]  lk_idx,
  output logic [ADDR_W-1:0] lk_start,
  output logic [ADDR_W-1:0] lk_cont,
  output logic [SIZE_W-1:0] lk_size,
  input  logic              up_en,
  input  logic [IDX_W-1:0]  up_idx,
  input  logic [ADDR_W-1:0] up_addr
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int PAD_W = ADDR_W - SIZE_W;

  logic [ADDR_W-1:0] start_mem [DEPTH];
  logic [ADDR_W-1:0] cont_mem  [DEPTH];
  logic [SIZE_W-1:0] size_mem  [DEPTH];

  // host may write start and size rows; the resume table is fed only by the sequencer
  always_ff @(posedge clk) begin
    if (hw_en && h_sel == TBL_START) start_mem[h_idx] <= hw_data;
    if (hw_en && h_sel == TBL_SIZE)  size_mem[h_idx]  <= hw_data[SIZE_W-1:0];
    if (up_en)                       cont_mem[up_idx] <= up_addr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hr_data <= '0;
    end else if (hr_en) begin
      case (h_sel)
        TBL_START: hr_data <= start_mem[h_idx];
        TBL_CONT:  hr_data <= cont_mem[h_idx];
        TBL_SIZE:  hr_data <= {{PAD_W{1'b0}}, size_mem[h_idx]};
        default:   hr_data <= '0;
      endcase
    end
  end

  assign lk_start = start_mem[lk_idx];
  assign lk_cont  = cont_mem[lk_idx];
  assign lk_size  = size_mem[lk_idx];
endmodule

// File: rtl/pkt_xfer_fsm.sv
module pkt_xfer_fsm
  import pkt_seq_pkg::*;
#(
  parameter int IDX_W  = 9,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SIZE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic [IDX_W-1:0]  dec_idx,
  input  logic              dec_cont,
  input  logic              dec_ok,
  input  logic              dec_flash,
  output logic [IDX_W-1:0]  lk_idx,
  input  logic [ADDR_W-1:0] lk_start,
  input  logic [ADDR_W-1:0] lk_cont,
  input  logic [SIZE_W-1:0] lk_size,
  output logic              up_en,
  output logic [IDX_W-1:0]  up_idx,
  output logic [ADDR_W-1:0] up_addr,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_last,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_last,
  output logic              mem_req,
  input  logic              mem_gnt,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_flash,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              busy,
  output logic              done,
  output logic              tag_err
);
  xfer_state_e       state;
  logic [IDX_W-1:0]  idx_q;
  logic              cont_q, write_q, flash_q, last_q;
  logic [ADDR_W-1:0] ptr_q, ptr_next;
  logic [SIZE_W-1:0] cnt_q;
  logic [DATA_W-1:0] buf_q;
  logic              done_q, err_q;
  logic              granted;

  assign ptr_next = ptr_q + ADDR_W'(1);
  assign granted  = mem_req && mem_gnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      idx_q   <= '0;
      cont_q  <= 1'b0;
      write_q <= 1'b0;
      flash_q <= 1'b0;
      last_q  <= 1'b0;
      ptr_q   <= '0;
      cnt_q   <= '0;
      buf_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (cmd_valid) begin
            if (dec_ok) begin
              idx_q   <= dec_idx;
              cont_q  <= dec_cont;
              write_q <= cmd_write;
              flash_q <= dec_flash;
              state   <= ST_FETCH;
            end else begin
              err_q <= 1'b1;
            end
          end
        end
        ST_FETCH: begin
          ptr_q <= cont_q ? lk_cont : lk_start;
          cnt_q <= lk_size;
          if (write_q) begin
            state <= ST_WDAT;
          end else if (lk_size == '0) begin
            state  <= ST_IDLE;
            done_q <= 1'b1;
          end else begin
            state <= ST_RREQ;
          end
        end
        ST_RREQ: begin
          if (mem_gnt) begin
            ptr_q <= ptr_next;
            cnt_q <= cnt_q - SIZE_W'(1);
            state <= ST_RWAIT;
          end
        end
        ST_RWAIT: begin
          if (mem_rvalid) begin
            buf_q <= mem_rdata;
            state <= ST_ROUT;
          end
        end
        ST_ROUT: begin
          if (rd_ready) begin
            if (cnt_q == '0) begin
              state  <= ST_IDLE;
              done_q <= 1'b1;
            end else begin
              state <= ST_RREQ;
            end
          end
        end
        ST_WDAT: begin
          if (wr_valid) begin
            buf_q  <= wr_data;
            last_q <= wr_last;
            state  <= ST_WREQ;
          end
        end
        ST_WREQ: begin
          if (mem_gnt) begin
            ptr_q <= ptr_next;
            if (last_q) begin
              state  <= ST_IDLE;
              done_q <= 1'b1;
            end else begin
              state <= ST_WDAT;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign lk_idx    = idx_q;
  assign up_en     = granted;
  assign up_idx    = idx_q;
  assign up_addr   = ptr_next;

  assign cmd_ready = (state == ST_IDLE);
  assign busy      = (state != ST_IDLE);
  assign wr_ready  = (state == ST_WDAT);
  assign rd_valid  = (state == ST_ROUT);
  assign rd_data   = buf_q;
  assign rd_last   = (state == ST_ROUT) && (cnt_q == '0);
  assign mem_req   = (state == ST_RREQ) || (state == ST_WREQ);
  assign mem_we    = (state == ST_WREQ);
  assign mem_addr  = ptr_q;
  assign mem_wdata = buf_q;
  assign mem_flash = (state == ST_WREQ) && flash_q;
  assign done      = done_q;
  assign tag_err   = err_q;

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R13
  AST_RD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data) && $stable(rd_last)); // R13
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && dec_ok |=> busy && !cmd_ready); // R12
  AST_BAD_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && !dec_ok |=> tag_err && !busy && !mem_req); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R12
  AST_FLASH_WR: assert property (@(posedge clk) disable iff (!rst_n)
    mem_flash |-> mem_req && mem_we); // R9
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_gnt |=> mem_addr == $past(mem_addr) + ADDR_W'(1)); // R5
endmodule

// File: rtl/pkt_tag_seq.sv
module pkt_tag_seq
  import pkt_seq_pkg::*;
#(
  parameter int TAG_W     = 12,
  parameter int IDX_W     = 9,
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int SIZE_W    = 12,
  parameter int FLASH_IDX = 511
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic              cfg_rd_en,
  input  logic [1:0]        cfg_sel,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] cfg_rdata,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [TAG_W-1:0]  cmd_tag,
  input  logic              cmd_write,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_last,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_last,
  output logic              mem_req,
  input  logic              mem_gnt,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_flash,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              busy,
  output logic              done,
  output logic              tag_err
);
  logic [IDX_W-1:0]  dec_idx, lk_idx, up_idx;
  logic              dec_cont, dec_ok, dec_flash, up_en;
  logic [ADDR_W-1:0] lk_start, lk_cont, up_addr;
  logic [SIZE_W-1:0] lk_size;

  pkt_tag_decode #(
    .TAG_W(TAG_W), .IDX_W(IDX_W), .FLASH_IDX(FLASH_IDX)
  ) u_decode (
    .tag(cmd_tag), .is_write(cmd_write), .idx(dec_idx),
    .use_cont(dec_cont), .tag_ok(dec_ok), .flash(dec_flash)
  );

  pkt_addr_tables #(
    .IDX_W(IDX_W), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W)
  ) u_tables (
    .clk(clk), .rst_n(rst_n),
    .hw_en(cfg_wr_en), .hr_en(cfg_rd_en), .h_sel(tbl_sel_e'(cfg_sel)),
    .h_idx(cfg_idx), .hw_data(cfg_wdata), .hr_data(cfg_rdata),
    .lk_idx(lk_idx), .lk_start(lk_start), .lk_cont(lk_cont), .lk_size(lk_size),
    .up_en(up_en), .up_idx(up_idx), .up_addr(up_addr)
  );

  pkt_xfer_fsm #(
    .IDX_W(IDX_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .dec_idx(dec_idx), .dec_cont(dec_cont), .dec_ok(dec_ok), .dec_flash(dec_flash),
    .lk_idx(lk_idx), .lk_start(lk_start), .lk_cont(lk_cont), .lk_size(lk_size),
    .up_en(up_en), .up_idx(up_idx), .up_addr(up_addr),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data), .wr_last(wr_last),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .rd_last(rd_last),
    .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_flash(mem_flash),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .tag_err(tag_err)
  );
endmodule

// File: tb/pkt_tag_seq_tb.sv
module pkt_tag_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0, cfg_rd_en = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [8:0]  cfg_idx = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic        cmd_valid = 1'b0, cmd_ready, cmd_write = 1'b0;
  logic [11:0] cmd_tag = '0;
  logic        wr_valid = 1'b0, wr_ready, wr_last = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_valid, rd_ready = 1'b1, rd_last;
  logic [31:0] rd_data;
  logic        mem_req, mem_gnt = 1'b1, mem_we, mem_flash, mem_rvalid = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic        busy, done, tag_err;

  int total = 0, bad = 0;
  int acc_cnt = 0, flash_cnt = 0, done_cnt = 0;
  logic stall = 1'b0;
  logic [31:0] model [256];
  logic last_err;

  pkt_tag_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_rd_en(cfg_rd_en),
    .cfg_sel(cfg_sel), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_tag(cmd_tag), .cmd_write(cmd_write),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data), .wr_last(wr_last),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .rd_last(rd_last),
    .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_flash(mem_flash), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .busy(busy), .done(done), .tag_err(tag_err)
  );

  always #5 clk = ~clk;

  // memory model: one access per grant, read data one cycle later
  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) model[i] <= 32'hC0DE_0000 | 32'(i);
    end else if (mem_req && mem_gnt) begin
      acc_cnt <= acc_cnt + 1;
      if (mem_we) begin
        model[mem_addr[7:0]] <= mem_wdata;
        if (mem_flash) flash_cnt <= flash_cnt + 1;
      end else begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= model[mem_addr[7:0]];
      end
    end
    if (rst_n && done) done_cnt <= done_cnt + 1;
  end

  always @(negedge clk) mem_gnt <= stall ? ~mem_gnt : 1'b1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic [1:0] sel, input logic [8:0] idx, input logic [31:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_sel = sel; cfg_idx = idx; cfg_wdata = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic host_rd(input logic [1:0] sel, input logic [8:0] idx, output logic [31:0] d);
    @(negedge clk);
    cfg_rd_en = 1'b1; cfg_sel = sel; cfg_idx = idx;
    @(negedge clk);
    cfg_rd_en = 1'b0;
    d = cfg_rdata;
  endtask

  task automatic send_cmd(input logic [11:0] tag, input logic wr);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_tag = tag; cmd_write = wr;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    last_err = tag_err;
  endtask

  // read one packet; checks beat count, data order, last flag, refusal while busy
  task automatic read_pkt(input string req, input logic [11:0] tag, input int n,
                          input logic [31:0] first, input int hold);
    int beats = 0, errs = 0, held = 0, refuse = 0, guard = 0;
    logic [31:0] hdat = '0;
    rd_ready = (hold == 0);
    send_cmd(tag, 1'b0);
    while (busy && guard < 2000) begin
      @(negedge clk);
      guard++;
      if (busy && cmd_ready) refuse++;
      if (rd_valid) begin
        if (!rd_ready && held < hold) begin
          if (held == 0) hdat = rd_data;
          else if (rd_data != hdat) errs++;
          held++;
        end else begin
          rd_ready = 1'b1;
          if (rd_data != (first + 32'(beats))) errs++;
          if (rd_last != (beats == n - 1)) errs++;
          beats++;
        end
      end
    end
    rd_ready = 1'b1;
    chk(beats == n, {req, " beat count"}, 32'(beats), 32'(n));
    chk(errs == 0, {req, " data/last"}, 32'(errs), 32'd0);
    chk(refuse == 0, "R12 cmd refused while busy", 32'(refuse), 32'd0);
  endtask

  task automatic write_pkt(input logic [11:0] tag, input int n, input logic [31:0] base);
    send_cmd(tag, 1'b1);
    for (int i = 0; i < n; i++) begin
      wr_valid = 1'b1; wr_data = base + 32'(i); wr_last = (i == n - 1);
      while (!wr_ready) @(negedge clk);
      @(negedge clk);
    end
    wr_valid = 1'b0; wr_last = 1'b0;
    while (busy) @(negedge clk);
  endtask

  task automatic t_reset;
    chk(!busy && cmd_ready && !mem_req && !rd_valid && !wr_ready, "R1 reset state",
        {27'd0, busy, cmd_ready, mem_req, rd_valid, wr_ready}, 32'h8);
  endtask

  task automatic t_cfg;
    logic [31:0] d;
    host_wr(2'd0, 9'd5, 32'h0000_0010);
    host_wr(2'd2, 9'd5, 32'hFFFF_F004);
    host_rd(2'd2, 9'd5, d);
    chk(d == 32'h4, "R2 size zero-extended", d, 32'h4);
    host_rd(2'd0, 9'd5, d);
    chk(d == 32'h10, "R2 start readback", d, 32'h10);
  endtask

  task automatic t_chain;
    logic [31:0] d;
    int a0;
    a0 = acc_cnt;
    read_pkt("R3 R6 start read", 12'd5, 4, 32'hC0DE_0010, 0);
    chk(acc_cnt - a0 == 4, "R6 access count", 32'(acc_cnt - a0), 32'd4);
    host_rd(2'd1, 9'd5, d);
    chk(d == 32'h14, "R5 resume after first", d, 32'h14);
    read_pkt("R4 resume read", 12'd2053, 4, 32'hC0DE_0014, 0);
    host_rd(2'd1, 9'd5, d);
    chk(d == 32'h18, "R5 resume after second", d, 32'h18);
    read_pkt("R3 alias tag", 12'd517, 4, 32'hC0DE_0010, 0);
  endtask

  task automatic t_write;
    logic [31:0] d;
    int f0;
    f0 = flash_cnt;
    host_wr(2'd0, 9'd7, 32'h40);
    host_wr(2'd2, 9'd7, 32'h1);
    write_pkt(12'd7, 3, 32'hDA7A_0000);
    chk(model[8'h40] == 32'hDA7A_0000 && model[8'h42] == 32'hDA7A_0002 &&
        model[8'h43] == 32'hC0DE_0043, "R7 write length from stream",
        model[8'h42], 32'hDA7A_0002);
    host_rd(2'd1, 9'd7, d);
    chk(d == 32'h43, "R5 resume after write", d, 32'h43);
    chk(flash_cnt == f0, "R9 no flash mark", 32'(flash_cnt), 32'(f0));
    host_wr(2'd1, 9'd7, 32'hDEAD_BEEF);
    host_rd(2'd1, 9'd7, d);
    chk(d == 32'h43, "R8 resume not host-writable", d, 32'h43);
  endtask

  task automatic t_invalid;
    int a0;
    a0 = acc_cnt;
    send_cmd(12'd0, 1'b0);
    chk(last_err && !busy, "R10 tag 0 rejected", {30'd0, last_err, busy}, 32'h2);
    send_cmd(12'd2048, 1'b1);
    chk(last_err && !busy, "R10 tag 2048 rejected", {30'd0, last_err, busy}, 32'h2);
    repeat (3) @(negedge clk);
    chk(acc_cnt == a0, "R10 no access", 32'(acc_cnt), 32'(a0));
  endtask

  task automatic t_zero;
    int a0, d0, g;
    host_wr(2'd0, 9'd9, 32'h80);
    host_wr(2'd2, 9'd9, 32'h0);
    a0 = acc_cnt; d0 = done_cnt; g = 0;
    send_cmd(12'd9, 1'b0);
    while (busy && g < 50) begin @(negedge clk); g++; end
    repeat (2) @(negedge clk);
    chk(done_cnt == d0 + 1 && acc_cnt == a0, "R11 zero-size read",
        32'(acc_cnt - a0), 32'd0);
  endtask

  task automatic t_flash;
    int f0;
    f0 = flash_cnt;
    host_wr(2'd0, 9'd511, 32'h60);
    write_pkt(12'd511, 2, 32'hF1A5_0000);
    chk(flash_cnt - f0 == 2, "R9 flash marked writes", 32'(flash_cnt - f0), 32'd2);
  endtask

  task automatic t_stall;
    int d0;
    host_wr(2'd0, 9'd20, 32'h20);
    host_wr(2'd2, 9'd20, 32'h3);
    d0 = done_cnt;
    stall = 1'b1;
    read_pkt("R13 stalled read", 12'd20, 3, 32'hC0DE_0020, 3);
    stall = 1'b0;
    @(negedge clk);
    chk(done_cnt == d0 + 1, "R12 single done pulse", 32'(done_cnt - d0), 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cfg();
    t_chain();
    t_write();
    t_invalid();
    t_zero();
    t_flash();
    t_stall();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule